// File: doc/BRIEF.md
# Receive RSSI and Timeout Supervisor

This block watches a radio receiver while it is in receive mode. Each cycle it compares the measured signal strength with a programmed threshold. The first time the strength is above the threshold, it raises a signal-strength interrupt. That interrupt stays set for the rest of the receive session.

Two timeout phases run one after the other. Both count a one-cycle bit-period tick in steps of sixteen bit periods per unit of their setting.
- The start phase begins when receive mode is entered. The signal-strength event ends it.
- The payload phase begins with that event. A payload-ready strobe ends it.

If either phase runs out before its ending event, a sticky timeout interrupt is raised. A setting of zero turns that phase's timer off. Dropping the receive-mode level clears the whole block, ready for the next session.

Top module: `rxsup_supervisor`

## Requirements
- R1: While reset is asserted and after it is released with `rx_en` low, `rssi_irq` and `timeout_irq` are 0.
- R2: When `rx_en` is 1 and `rssi_val` is strictly greater than `rssi_thr` (unsigned compare), `rssi_irq` is 1 from the next cycle on. Equality does not trigger it. Once set, it stays 1 until `rx_en` goes low, even if the strength falls back below the threshold.
- R3: With `rx_start_to` = N (N > 0) and no signal-strength event, `timeout_irq` becomes 1 in the cycle that follows the 16·N-th `bit_tick` after `rx_en` rose. It is still 0 after the (16·N − 1)-th tick.
- R4: After the signal-strength event, `rssi_to` = M (M > 0) makes `timeout_irq` rise in the cycle that follows the 16·M-th `bit_tick` counted after the event cycle. A tick in the event cycle itself does not count.
- R5: A setting of 0 disables its phase. No number of ticks raises a timeout in that phase.
- R6: A `payload_rdy` pulse during the payload phase ends that phase with no timeout. A pulse before the signal-strength event is ignored, and the payload phase then still times out normally.
- R7: If `payload_rdy` coincides with the tick that would end the payload phase, no timeout is raised.
- R8: If the signal-strength event coincides with the tick that would end the start phase, `rssi_irq` is raised, no timeout is raised, and the payload phase begins.
- R9: `rx_en` low clears both interrupts in the next cycle and discards any partial count. A new session counts its ticks from zero.
- R10: Cycles without `bit_tick` do not advance either timer. Once raised, `timeout_irq` stays 1 until `rx_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive-mode level |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rssi_val | input | 8 | Measured signal strength |
| rssi_thr | input | 8 | Signal-strength threshold |
| rx_start_to | input | 8 | Start-phase timeout, in units of 16 bit periods, 0 = off |
| rssi_to | input | 8 | Payload-phase timeout, in units of 16 bit periods, 0 = off |
| payload_rdy | input | 1 | Payload-ready strobe |
| rssi_irq | output | 1 | Sticky signal-strength interrupt |
| timeout_irq | output | 1 | Sticky timeout interrupt |

## Verification
The hardest cases to reach are the two same-cycle races. In one, the final counting tick meets the signal-strength event. In the other, the final tick meets the payload strobe. Each race exists for only one cycle out of 16·N ticks.

Directed sequences reach these cases by counting ticks in the bench. They hold the settings at 1 and deliver exactly fifteen ticks. The event or strobe then goes in together with the sixteenth tick.

Seeded random sessions, with sparse ticks, random settings and early exits from receive mode, are compared every cycle against a cycle-level reference model in the bench.

// File: rtl/rxsup_pkg.sv
package rxsup_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WAIT_RSSI = 2'd1,
    PH_WAIT_PAY  = 2'd2,
    PH_DONE      = 2'd3
  } rxsup_phase_e;
endpackage

// File: rtl/rxsup_rssi_cmp.sv
module rxsup_rssi_cmp #(
  parameter int unsigned RSSI_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [RSSI_W-1:0] rssi_val,
  input  logic [RSSI_W-1:0] rssi_thr,
  output logic              hit,
  output logic              irq
);
  logic irq_d;

  assign hit   = rx_en & (rssi_val > rssi_thr);
  assign irq_d = rx_en & (irq | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  AST_HIT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rssi_val > rssi_thr) |=> irq); // R2
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && irq) |=> irq); // R2
endmodule

// File: rtl/rxsup_bit_timer.sv
module rxsup_bit_timer #(
  parameter int unsigned SET_W    = 8,
  parameter int unsigned SCALE_SH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [SET_W-1:0] setting,
  output logic             expire
);
  localparam int unsigned CNT_W = SET_W + SCALE_SH;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             armed;
  logic             cnt_en;

  assign limit  = {setting, {SCALE_SH{1'b0}}};
  assign armed  = run & (setting != '0);
  assign cnt_en = armed & tick;
  assign expire = cnt_en & (cnt_q >= (limit - CNT_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_NO_TICK_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R10
  AST_ZERO_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (setting == '0) |-> !expire); // R5
endmodule

// File: rtl/rxsup_phase_ctrl.sv
module rxsup_phase_ctrl
  import rxsup_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         rssi_hit,
  input  logic         payload_rdy,
  input  logic         expire,
  output rxsup_phase_e phase,
  output logic         tmr_clr,
  output logic         tmr_run,
  output logic         timeout_irq
);
  rxsup_phase_e state_q;
  rxsup_phase_e state_d;
  logic         to_q;
  logic         to_d;
  logic         to_set;

  always_comb begin
    state_d = state_q;
    to_set  = 1'b0;
    if (!rx_en) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE:      state_d = rssi_hit ? PH_WAIT_PAY : PH_WAIT_RSSI;
        PH_WAIT_RSSI: begin
          if (rssi_hit) begin
            state_d = PH_WAIT_PAY;
          end else if (expire) begin
            state_d = PH_DONE;
            to_set  = 1'b1;
          end
        end
        PH_WAIT_PAY: begin
          if (payload_rdy) begin
            state_d = PH_DONE;
          end else if (expire) begin
            state_d = PH_DONE;
            to_set  = 1'b1;
          end
        end
        default:      state_d = PH_DONE;
      endcase
    end
  end

  assign to_d        = rx_en & (to_q | to_set);
  assign tmr_clr     = !rx_en || (state_d != state_q);
  assign tmr_run     = (state_q == PH_WAIT_RSSI) || (state_q == PH_WAIT_PAY);
  assign phase       = state_q;
  assign timeout_irq = to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      to_q    <= to_d;
    end
  end

  AST_PAYLOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WAIT_PAY && payload_rdy && !to_q) |=> !to_q); // R7
  AST_RSSI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WAIT_RSSI && rssi_hit && !to_q) |=> !to_q); // R8
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && to_q) |=> to_q); // R10
endmodule

// File: rtl/rxsup_supervisor.sv
module rxsup_supervisor
  import rxsup_pkg::*;
#(
  parameter int unsigned RSSI_W   = 8,
  parameter int unsigned SET_W    = 8,
  parameter int unsigned SCALE_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_tick,
  input  logic [RSSI_W-1:0] rssi_val,
  input  logic [RSSI_W-1:0] rssi_thr,
  input  logic [SET_W-1:0]  rx_start_to,
  input  logic [SET_W-1:0]  rssi_to,
  input  logic              payload_rdy,
  output logic              rssi_irq,
  output logic              timeout_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             hit;
  logic             expire;
  logic             tmr_clr;
  logic             tmr_run;
  logic [SET_W-1:0] cur_setting;
  rxsup_phase_e     phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cur_setting = (phase == PH_WAIT_PAY) ? rssi_to : rx_start_to;

  rxsup_rssi_cmp #(.RSSI_W(RSSI_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_en    (rx_en),
    .rssi_val (rssi_val),
    .rssi_thr (rssi_thr),
    .hit      (hit),
    .irq      (rssi_irq)
  );

  rxsup_bit_timer #(.SET_W(SET_W), .SCALE_SH(SCALE_SH)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .tick    (bit_tick),
    .setting (cur_setting),
    .expire  (expire)
  );

  rxsup_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rx_en       (rx_en),
    .rssi_hit    (hit),
    .payload_rdy (payload_rdy),
    .expire      (expire),
    .phase       (phase),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .timeout_irq (timeout_irq)
  );

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rx_en |=> (!rssi_irq && !timeout_irq)); // R9
  AST_NOT_RX_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_IDLE) |-> !expire); // R9
endmodule

// File: tb/test_rxsup_supervisor.sv
module test_rxsup_supervisor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, bit_tick, payload_rdy;
  logic [7:0] rssi_val, rssi_thr, rx_start_to, rssi_to;
  logic       rssi_irq, timeout_irq;

  int checks   = 0;
  int failures = 0;
  string cur_req = "R1";

  // reference model state
  bit m_rssi, m_to;
  int m_ph, m_cnt;

  always #10 clk = ~clk;

  rxsup_supervisor i_rxsup_supervisor (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
    .rssi_val(rssi_val), .rssi_thr(rssi_thr), .rx_start_to(rx_start_to),
    .rssi_to(rssi_to), .payload_rdy(payload_rdy),
    .rssi_irq(rssi_irq), .timeout_irq(timeout_irq)
  );

  function automatic bit exp_hit(input logic [7:0] v, input logic [7:0] t);
    return v > t;
  endfunction

  function automatic int phase_len(input logic [7:0] s);
    return int'(s) * 16;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit h;
    h = exp_hit(rssi_val, rssi_thr);
    if (!rx_en) begin
      m_rssi = 0; m_to = 0; m_ph = 0; m_cnt = 0;
    end else begin
      m_rssi = m_rssi | h;
      case (m_ph)
        0: begin m_ph = h ? 2 : 1; m_cnt = 0; end
        1: if (h) begin m_ph = 2; m_cnt = 0; end
           else if (bit_tick && rx_start_to != 0) begin
             m_cnt++;
             if (m_cnt >= phase_len(rx_start_to)) begin m_ph = 3; m_to = 1; end
           end
        2: if (payload_rdy) m_ph = 3;
           else if (bit_tick && rssi_to != 0) begin
             m_cnt++;
             if (m_cnt >= phase_len(rssi_to)) begin m_ph = 3; m_to = 1; end
           end
        default: ;
      endcase
    end
  endtask

  // one cycle: inputs already set at negedge; model advances; compare at next negedge
  task automatic cyc(input bit rx, input bit tk, input logic [7:0] rv, input bit pay);
    rx_en = rx; bit_tick = tk; rssi_val = rv; payload_rdy = pay;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(cur_req, "model rssi_irq", rssi_irq, m_rssi);
    check(cur_req, "model timeout_irq", timeout_irq, m_to);
  endtask

  task automatic ticks(input int n, input logic [7:0] rv);
    for (int i = 0; i < n; i++) cyc(1, 1, rv, 0);
  endtask

  task automatic leave_rx();
    cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_en = 0; bit_tick = 0; payload_rdy = 0;
    rssi_val = 0; rssi_thr = 8'hE4; rx_start_to = 0; rssi_to = 0;
    m_rssi = 0; m_to = 0; m_ph = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1", "rssi_irq in reset", rssi_irq, 1'b0);
    check("R1", "timeout_irq in reset", timeout_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "rssi_irq after reset", rssi_irq, 1'b0);
    check("R1", "timeout_irq after reset", timeout_irq, 1'b0);

    // R2: equality does not trigger, strict greater does, sticky afterwards
    cur_req = "R2"; rx_start_to = 0; rssi_to = 0;
    cyc(1, 0, 8'hE4, 0);
    check("R2", "equal no irq", rssi_irq, 1'b0);
    cyc(1, 0, 8'hE5, 0);
    check("R2", "greater sets irq", rssi_irq, 1'b1);
    cyc(1, 0, 8'h10, 0); cyc(1, 0, 8'h10, 0);
    check("R2", "irq stays after drop", rssi_irq, 1'b1);
    leave_rx();
    check("R9", "exit clears rssi_irq", rssi_irq, 1'b0);

    // R3 + R10: start phase with gaps between ticks
    cur_req = "R3"; rx_start_to = 8'd1;
    cyc(1, 0, 8'h00, 0);
    for (int i = 0; i < 15; i++) begin cyc(1, 1, 8'h00, 0); cyc(1, 0, 8'h00, 0); end
    repeat (5) cyc(1, 0, 8'h00, 0);
    check("R10", "no tick no advance", timeout_irq, 1'b0);
    check("R3", "15 ticks no timeout", timeout_irq, 1'b0);
    cyc(1, 1, 8'h00, 0);
    check("R3", "16th tick timeout", timeout_irq, 1'b1);
    ticks(3, 8'hFF);
    check("R10", "timeout sticky", timeout_irq, 1'b1);
    leave_rx();
    check("R9", "exit clears timeout", timeout_irq, 1'b0);

    // R5: zero disables start phase
    cur_req = "R5"; rx_start_to = 0;
    cyc(1, 0, 8'h00, 0);
    ticks(200, 8'h00);
    check("R5", "zero start setting", timeout_irq, 1'b0);
    // R5: zero disables payload phase
    rssi_to = 0;
    cyc(1, 1, 8'hF0, 0);
    ticks(200, 8'h00);
    check("R5", "zero payload setting", timeout_irq, 1'b0);
    leave_rx();

    // R8: event coincides with final start tick; then R4 payload phase
    cur_req = "R8"; rx_start_to = 8'd1; rssi_to = 8'd2;
    cyc(1, 0, 8'h00, 0);
    ticks(15, 8'h00);
    cyc(1, 1, 8'hF0, 0);
    check("R8", "rssi wins rssi_irq", rssi_irq, 1'b1);
    check("R8", "rssi wins no timeout", timeout_irq, 1'b0);
    cur_req = "R4";
    ticks(31, 8'h00);
    check("R4", "31 ticks no timeout", timeout_irq, 1'b0);
    ticks(1, 8'h00);
    check("R4", "32nd tick timeout", timeout_irq, 1'b1);
    leave_rx();

    // R6: early payload ignored, later payload cancels
    cur_req = "R6"; rx_start_to = 0; rssi_to = 8'd1;
    cyc(1, 0, 8'h00, 0);
    cyc(1, 0, 8'h00, 1);
    cyc(1, 1, 8'hF0, 0);
    ticks(16, 8'h00);
    check("R6", "early payload ignored", timeout_irq, 1'b1);
    leave_rx();
    cyc(1, 1, 8'hF0, 0);
    ticks(5, 8'h00);
    cyc(1, 0, 8'h00, 1);
    ticks(40, 8'h00);
    check("R6", "payload cancels", timeout_irq, 1'b0);
    leave_rx();

    // R7: payload with final payload tick
    cur_req = "R7"; rssi_to = 8'd1;
    cyc(1, 0, 8'hF0, 0);
    ticks(15, 8'h00);
    cyc(1, 1, 8'h00, 1);
    check("R7", "payload wins", timeout_irq, 1'b0);
    ticks(40, 8'h00);
    check("R7", "still no timeout", timeout_irq, 1'b0);
    leave_rx();

    // R9: partial count discarded on exit
    cur_req = "R9"; rx_start_to = 8'd1;
    cyc(1, 0, 8'h00, 0);
    ticks(10, 8'h00);
    leave_rx();
    cyc(1, 0, 8'h00, 0);
    ticks(15, 8'h00);
    check("R9", "restart from zero", timeout_irq, 1'b0);
    ticks(1, 8'h00);
    check("R9", "full count after restart", timeout_irq, 1'b1);
    leave_rx();

    // random sessions vs model
    cur_req = "R10";
    for (int s = 0; s < 60; s++) begin
      rx_start_to = 8'($urandom_range(0, 3));
      rssi_to     = 8'($urandom_range(0, 3));
      rssi_thr    = 8'($urandom_range(150, 250));
      for (int c = 0; c < int'($urandom_range(20, 200)); c++) begin
        cyc(($urandom_range(0, 99) != 0), ($urandom_range(0, 2) == 0),
            ($urandom_range(0, 30) == 0) ? 8'hFF : 8'($urandom_range(0, 150)),
            ($urandom_range(0, 40) == 0));
      end
      leave_rx();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule